// File: doc/BRIEF.md
# Periodic Down-Counting Tick Timer

This block is a periodic interval timer for a processor subsystem. A counter 24 bits wide counts down once per count enable. When it steps from one to zero it sets a sticky wrap flag and, if software asked for it, pulses an interrupt request for one cycle. On the next count enable after zero it loads the reload value again, so a period lasts reload+1 count enables. Software sees four 32-bit word registers on a simple single-cycle bus: control/status, reload, current value and a read-only calibration word.

The count enable comes from one of two places. It can be every cycle of the block's own clock. It can also be a slower external reference signal, which is brought in through a two-stage synchronizer and turned into a one-cycle enable on each rising edge. Software can write the current-value register at any time, including while the counter is stopped. That write clears the count, and the zero count it leaves stays in place until counting is enabled. The first counting step after enabling then loads the reload register as it stands at that moment. A stale period from an earlier configuration can never come back.

Top module: `tick_timer`

## Requirements
- R1: After reset, control/status, reload and current value all read as zero, so the counter is stopped, the interrupt is off and the external reference is selected. The irq output is low.
- R2: Register map on word offsets of bus_addr: 0x0 control/status, with run in bit 0, interrupt enable in bit 1, clock select in bit 2 and the wrap flag in bit 16. 0x4 is reload, with 24 bits stored and bits 31:24 read as zero. 0x8 is current value. 0xC returns the CAL_VALUE parameter and ignores writes. Any other address reads zero.
- R3: A write of any data to offset 0x8 clears the count and the wrap flag on that edge, and irq is low in the following cycle.
- R4: A count enable that finds the count at zero loads the reload value. Otherwise the count decrements. With the own clock selected, the wrap flag becomes readable reload+2 one-cycle reads after the enabling write.
- R5: While run is 0 the count holds. After a current-value write made while stopped, the first count enable after run is set loads the reload value written most recently.
- R6: The wrap flag sets on a counting step from 1 to 0, and never while run is 0. A read of offset 0x0 clears it, except on an edge where it sets.
- R7: With interrupt enable at 1, irq is high for exactly one cycle, following the same edge that sets the wrap flag. Otherwise irq stays low.
- R8: Clock select 1 makes every cycle a count enable. Clock select 0 makes each rising level on ext_ref, first sampled at edge k, one count enable applied at edge k+2. A steady ext_ref gives no count.
- R9: A reload write made while counting does not change the count in progress. It takes effect at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| ext_ref | input | 1 | Asynchronous external reference tick |
| irq | output | 1 | One-cycle interrupt request |

## Verification
The count is driven two ways: from the own clock, where every cycle counts, and from a toggled external reference, where only synchronized rising edges count. The two sequences are clearly separated, since a steady reference must leave the count frozen. A directed sequence enables the counter with a long reload, waits for the wrap, stops the counter, shortens the reload, clears the count and enables again. The number of polls until the flag shows distinguishes loading the newest reload value from resuming an old period. Random mixes of writes to control, reload and current value, reads that clear the flag, and stops in mid-count are compared cycle by cycle against a bench model. This exposes the same-edge conflicts: a count enable against a current-value write, and a flag set against a flag-clearing read.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    localparam int unsigned BUS_W = 32;

    // Register byte offsets
    localparam logic [3:0] OFS_CTRL    = 4'h0;
    localparam logic [3:0] OFS_RELOAD  = 4'h4;
    localparam logic [3:0] OFS_CURRENT = 4'h8;
    localparam logic [3:0] OFS_CALIB   = 4'hC;

    // Control/status bit positions
    localparam int unsigned BIT_RUN    = 0;
    localparam int unsigned BIT_IRQEN  = 1;
    localparam int unsigned BIT_CORE   = 2;
    localparam int unsigned BIT_WRAP   = 16;

    typedef struct packed {
        logic core_clk;   // 1: own clock, 0: external reference
        logic irq_en;
        logic run;
    } ctl_t;

endpackage

// File: rtl/tick_ref_sync.sv
module tick_ref_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    output logic ref_pulse
);
    localparam int unsigned PIPE_W = SYNC_STAGES + 1;

    typedef struct packed {
        logic [PIPE_W-1:0] pipe;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pipe = {st_q.pipe[PIPE_W-2:0], ref_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Rising edge seen at the end of the synchronizer
    assign ref_pulse = st_q.pipe[SYNC_STAGES-1] & ~st_q.pipe[SYNC_STAGES];
endmodule

// File: rtl/tick_regs.sv
module tick_regs
    import tick_timer_pkg::*;
#(
    parameter int unsigned CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  logic             reload_we,
    input  logic [BUS_W-1:0] wdata,
    output ctl_t             ctl,
    output logic [CNT_W-1:0] reload
);
    typedef struct packed {
        ctl_t             ctl;
        logic [CNT_W-1:0] reload;
    } reg_st_t;

    reg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctrl_we) begin
            st_d.ctl.run      = wdata[BIT_RUN];
            st_d.ctl.irq_en   = wdata[BIT_IRQEN];
            st_d.ctl.core_clk = wdata[BIT_CORE];
        end
        if (reload_we) st_d.reload = wdata[CNT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctl    = st_q.ctl;
    assign reload = st_q.reload;
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
    parameter int unsigned CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_en,
    input  logic             clear,
    input  logic             flag_clr,
    input  logic             irq_en,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count,
    output logic             flag,
    output logic             irq_pulse
);
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             flag;
        logic             irq;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (clear) begin
            // Zero count doubles as the pending-reload marker
            st_d.cnt  = CNT_ZERO;
            st_d.flag = 1'b0;
        end else begin
            if (flag_clr) st_d.flag = 1'b0;
            if (count_en) begin
                if (st_q.cnt == CNT_ZERO) begin
                    st_d.cnt = reload_val;
                end else begin
                    st_d.cnt = st_q.cnt - CNT_ONE;
                    if (st_q.cnt == CNT_ONE) begin
                        st_d.flag = 1'b1;
                        st_d.irq  = irq_en;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count     = st_q.cnt;
    assign flag      = st_q.flag;
    assign irq_pulse = st_q.irq;
endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int unsigned  CNT_W       = 24,
    parameter int unsigned  ADDR_W      = 4,
    parameter int unsigned  SYNC_STAGES = 2,
    parameter logic [31:0]  CAL_VALUE   = 32'h4000_2710
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              ext_ref,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_RELOAD  = ADDR_W'(OFS_RELOAD);
    localparam logic [ADDR_W-1:0] A_CURRENT = ADDR_W'(OFS_CURRENT);
    localparam logic [ADDR_W-1:0] A_CALIB   = ADDR_W'(OFS_CALIB);

    logic             wr_acc, rd_acc;
    logic             ctrl_we, reload_we, cur_we, ctrl_rd;
    logic             ref_pulse, count_en;
    ctl_t             ctl_q;
    logic [CNT_W-1:0] reload_val, cur_val;
    logic             flag_val;

    assign wr_acc    = bus_sel &  bus_wr;
    assign rd_acc    = bus_sel & ~bus_wr;
    assign ctrl_we   = wr_acc && (bus_addr == A_CTRL);
    assign reload_we = wr_acc && (bus_addr == A_RELOAD);
    assign cur_we    = wr_acc && (bus_addr == A_CURRENT);
    assign ctrl_rd   = rd_acc && (bus_addr == A_CTRL);

    tick_ref_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_in    (ext_ref),
        .ref_pulse (ref_pulse)
    );

    tick_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_we   (ctrl_we),
        .reload_we (reload_we),
        .wdata     (bus_wdata),
        .ctl       (ctl_q),
        .reload    (reload_val)
    );

    assign count_en = ctl_q.run & (ctl_q.core_clk | ref_pulse);

    tick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .count_en   (count_en),
        .clear      (cur_we),
        .flag_clr   (ctrl_rd),
        .irq_en     (ctl_q.irq_en),
        .reload_val (reload_val),
        .count      (cur_val),
        .flag       (flag_val),
        .irq_pulse  (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (rd_acc) begin
            if (bus_addr == A_CTRL) begin
                bus_rdata[BIT_RUN]   = ctl_q.run;
                bus_rdata[BIT_IRQEN] = ctl_q.irq_en;
                bus_rdata[BIT_CORE]  = ctl_q.core_clk;
                bus_rdata[BIT_WRAP]  = flag_val;
            end else if (bus_addr == A_RELOAD) begin
                bus_rdata[CNT_W-1:0] = reload_val;
            end else if (bus_addr == A_CURRENT) begin
                bus_rdata[CNT_W-1:0] = cur_val;
            end else if (bus_addr == A_CALIB) begin
                bus_rdata = CAL_VALUE;
            end
        end
    end
endmodule

// File: rtl/tick_timer_checker.sv
module tick_timer_checker #(
    parameter int unsigned CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             count_en,
    input logic             cur_wr,
    input logic [CNT_W-1:0] cur,
    input logic [CNT_W-1:0] reload,
    input logic             flag,
    input logic             irq
);
    assert_clear_on_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cur_wr |=> (cur == '0 && !flag && !irq));

    assert_reload_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (count_en && !cur_wr && cur == '0) |=> (cur == $past(reload)));

    assert_hold_when_stopped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cur_wr) |=> $stable(cur));

    assert_flag_only_on_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> ($past(run) && $past(count_en) && $past(cur) == CNT_W'(1)));

    assert_irq_with_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag);

    assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
endmodule

bind tick_timer tick_timer_checker #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (ctl_q.run),
    .count_en (count_en),
    .cur_wr   (cur_we),
    .cur      (cur_val),
    .reload   (reload_val),
    .flag     (flag_val),
    .irq      (irq)
);

// File: tb/tick_timer_test.sv
module tick_timer_test;
    localparam logic [31:0] CAL = 32'h4000_2710;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0, wr = 1'b0, ext_ref = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    int          checks = 0, errors = 0;

    always #5 clk = ~clk;

    tick_timer #(.CAL_VALUE(CAL)) uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .ext_ref(ext_ref), .irq(irq)
    );

    // Bench model built from the requirements
    logic        m_run, m_ie, m_core, m_flag, m_irq;
    logic [23:0] m_rel, m_cur;
    logic [2:0]  m_s;

    always @(posedge clk) begin : model
        logic tk, f, ir;
        logic [23:0] c;
        if (!rst_n) begin
            m_run <= 0; m_ie <= 0; m_core <= 0; m_flag <= 0; m_irq <= 0;
            m_rel <= 0; m_cur <= 0; m_s <= 0;
        end else begin
            tk = m_run & (m_core | (m_s[1] & ~m_s[2]));   // R8
            m_s <= {m_s[1:0], ext_ref};
            c = m_cur; f = m_flag; ir = 1'b0;
            if (sel && wr && addr == 4'h8) begin
                c = '0; f = 1'b0;                          // R3
            end else begin
                if (sel && !wr && addr == 4'h0) f = 1'b0;  // R6
                if (tk) begin
                    if (m_cur == 0) c = m_rel;             // R4
                    else begin
                        c = m_cur - 1'b1;
                        if (m_cur == 1) begin f = 1'b1; ir = m_ie; end
                    end
                end
            end
            m_cur <= c; m_flag <= f; m_irq <= ir;
            if (sel && wr && addr == 4'h0) {m_core, m_ie, m_run} <= wdata[2:0];
            if (sel && wr && addr == 4'h4) m_rel <= wdata[23:0];
        end
    end

    function automatic logic [31:0] exp_rd(input logic [3:0] a);
        case (a)
            4'h0:    return {15'b0, m_flag, 13'b0, m_core, m_ie, m_run};
            4'h4:    return {8'b0, m_rel};
            4'h8:    return {8'b0, m_cur};
            4'hC:    return CAL;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] a);
        case (a)
            4'h0:    return "R6";
            4'h4:    return "R9";
            4'h8:    return "R4";
            default: return "R2";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic s, input logic w, input logic [3:0] a,
                        input logic [31:0] d, input string tag, output logic [31:0] got);
        @(negedge clk);
        sel = s; wr = w; addr = a; wdata = d;
        #1;
        chk("R7", {31'b0, irq}, {31'b0, m_irq});
        got = rdata;
        if (s && !w) chk(tag, rdata, exp_rd(a));
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        logic [31:0] g;
        step(1'b1, 1'b1, a, d, "", g);
    endtask

    task automatic rd_reg(input logic [3:0] a, input string tag, output logic [31:0] g);
        step(1'b1, 1'b0, a, 32'h0, tag, g);
    endtask

    task automatic idle(input int n);
        logic [31:0] g;
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 4'h0, 32'h0, "", g);
    endtask

    task automatic polls_to_flag(output int n);
        logic [31:0] g;
        n = 0;
        for (int i = 1; i <= 200; i++) begin
            rd_reg(4'h0, "R6", g);
            if (g[16]) begin n = i; break; end
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] g;
        int n;
        void'($urandom(32'd7391));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        chk("R1", {31'b0, irq}, 32'h0);
        rd_reg(4'h0, "R1", g); chk("R1", g, 32'h0);
        rd_reg(4'h4, "R1", g); chk("R1", g, 32'h0);
        rd_reg(4'h8, "R1", g); chk("R1", g, 32'h0);

        // R2 map
        wr_reg(4'h4, 32'hFFFF_FFFF);
        rd_reg(4'h4, "R2", g); chk("R2", g, 32'h00FF_FFFF);
        wr_reg(4'hC, 32'h1234_5678);
        rd_reg(4'hC, "R2", g); chk("R2", g, CAL);
        rd_reg(4'h1, "R2", g); chk("R2", g, 32'h0);
        wr_reg(4'h0, 32'hFFFF_FFF8);
        rd_reg(4'h0, "R2", g); chk("R2", g, 32'h0);

        // R4/R5: long period, stop, shorter reload, clear, restart
        wr_reg(4'h4, 32'd20);
        wr_reg(4'h8, 32'h0);
        wr_reg(4'h0, 32'h5);
        polls_to_flag(n); chk("R4", n, 22);
        wr_reg(4'h0, 32'h4);
        wr_reg(4'h4, 32'd5);
        wr_reg(4'h8, 32'hA5A5_A5A5);
        idle(10);
        rd_reg(4'h8, "R5", g); chk("R5", g, 32'h0);
        rd_reg(4'h0, "R6", g); chk("R6", g[16], 32'h0);
        wr_reg(4'h0, 32'h5);
        polls_to_flag(n); chk("R5", n, 7);

        // R3: clear while running with interrupt on
        wr_reg(4'h4, 32'd4);
        wr_reg(4'h8, 32'h0);
        wr_reg(4'h0, 32'h7);
        idle(8);
        wr_reg(4'h8, 32'hFFFF_FFFF);
        rd_reg(4'h8, "R3", g); chk("R3", g, 32'h0);
        chk("R3", {31'b0, irq}, 32'h0);
        rd_reg(4'h0, "R3", g); chk("R3", g[16], 32'h0);

        // R9: reload change during a period
        wr_reg(4'h0, 32'h4);
        wr_reg(4'h4, 32'd30);
        wr_reg(4'h8, 32'h0);
        wr_reg(4'h0, 32'h7);
        idle(5);
        wr_reg(4'h4, 32'd3);
        rd_reg(4'h8, "R9", g); chk("R9", (g > 32'd3) ? 32'h1 : 32'h0, 32'h1);
        polls_to_flag(n);
        polls_to_flag(n); chk("R9", n, 4);

        // R8: external reference
        wr_reg(4'h0, 32'h0);
        wr_reg(4'h4, 32'd3);
        wr_reg(4'h8, 32'h0);
        wr_reg(4'h0, 32'h1);
        idle(20);
        rd_reg(4'h8, "R8", g); chk("R8", g, 32'h0);
        ext_ref = 1'b1; idle(6);
        rd_reg(4'h8, "R8", g); chk("R8", g, 32'd3);
        ext_ref = 1'b0; idle(6);
        rd_reg(4'h8, "R8", g); chk("R8", g, 32'd3);
        ext_ref = 1'b1; idle(6);
        rd_reg(4'h8, "R8", g); chk("R8", g, 32'd2);

        // Random mix checked against the model
        for (int i = 0; i < 4000; i++) begin
            int unsigned r;
            r = $urandom_range(0, 99);
            if ($urandom_range(0, 3) == 0) ext_ref = ~ext_ref;
            if (r < 8) begin
                logic [31:0] d;
                d = $urandom;
                d[0] = ($urandom_range(0, 3) != 0);
                wr_reg(4'h0, d);
            end else if (r < 14) wr_reg(4'h4, $urandom_range(0, 12));
            else if (r < 18)     wr_reg(4'h8, $urandom);
            else if (r < 50) begin
                logic [3:0] a;
                a = 4'($urandom_range(0, 3) * 4);
                rd_reg(a, tag_of(a), g);
            end else idle(1);
        end
        idle(2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule